// File: doc/BRIEF.md
# Daisy-Chain Bus Arbiter and Requester

This block arbitrates a shared backplane bus among a row of boards on one request level. A central arbiter, placed at the first slot, watches the wired shared request and bus-busy lines and issues a grant that ripples slot by slot through each board's grant-in and grant-out. A board with nothing to do passes the grant on. A board that is waiting for the bus stops the grant, takes the bus and holds bus busy until its work is done.

Each board moves data in words of a fixed number of clocks. In single-word mode a board gives the bus up after every word and must win it again for the next one. In block mode it keeps the bus word after word while it still has work pending. When one board has held the bus too long and another is waiting, the arbiter asserts bus clear. The owner then finishes its current word and lets go.

The top module holds the arbiter and a parameterised chain of requesters. It models the open-drain request and busy lines as wired-AND of active-low drivers.

Top module: `daisy_arb_top`

## Requirements
- R1: The shared request line `br_n_o` is low whenever at least one board with `req_i` high is waiting and does not own the bus. Out of reset it is high.
- R2: The arbiter drives its grant low (`grant_chain_o[0]` = 0) only in the cycle after one in which `bbsy_n_o` was high and `br_n_o` was low.
- R3: A board that is not waiting copies its grant input to the next slot, so `grant_chain_o[k+1]` equals `grant_chain_o[k]` for such a board.
- R4: A waiting board that sees its grant input low while the bus is free takes the bus at the next clock. It raises `own_o[k]`, pulls `bbsy_n_o` low and holds the grant to later slots high.
- R5: When several boards wait together, the one nearest the arbiter (lowest index) wins.
- R6: Once the arbiter sees `bbsy_n_o` low while granting, it raises its grant at the next clock.
- R7: In single-word mode (`block_i[k]` = 0) the owner releases the bus at the clock that ends each word. A word lasts `WORD_CYC` clocks, and `word_done_o[k]` is high in its last clock.
- R8: In block mode (`block_i[k]` = 1) the owner keeps the bus across word boundaries while `req_i[k]` stays high and bus clear is not asserted. If no other board waits, it keeps it past `HOLD_LIMIT` cycles.
- R9: When an owner has held the bus for `HOLD_LIMIT` cycles and the request line is low, the arbiter pulls `bclr_n_o` low. The owner ends its current word and releases, so `bclr_n_o` stays low for at most `WORD_CYC`+1 cycles.
- R10: At most one bit of `own_o` is high in any cycle.
- R11: After reset, no board owns the bus and `bbsy_n_o`, `bclr_n_o`, `br_n_o` and the whole grant chain are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_SLOTS | Per-board work pending |
| block_i | input | N_SLOTS | Per-board transfer mode: 1 block, 0 single word |
| own_o | output | N_SLOTS | Board currently owns the bus |
| word_done_o | output | N_SLOTS | Last clock of an owned word |
| grant_chain_o | output | N_SLOTS | Grant seen at each slot's input, active low |
| br_n_o | output | 1 | Shared bus request, active low |
| bbsy_n_o | output | 1 | Shared bus busy, active low |
| bclr_n_o | output | 1 | Bus clear from the arbiter, active low |

## Verification
The hardest case to reach from the ports is a bus clear that pre-empts a block transfer. To get there, one board must already own the bus in block mode and keep requesting, while a second board starts waiting and stays waiting long enough for the hold counter to expire. The bench first lets a block owner run well past the hold limit with no competitor and confirms that no clear appears. It then raises a competitor's request, waits for the clear, and measures the time until the bus is released and the competitor becomes the new owner.

// File: rtl/daisy_arb_pkg.sv
package daisy_arb_pkg;
  typedef enum logic [1:0] {ARB_IDLE, ARB_GRANT, ARB_BUSY} arb_state_e;
  typedef enum logic [1:0] {RQ_IDLE, RQ_WAIT, RQ_OWN} rq_state_e;
endpackage

// File: rtl/daisy_arb_central.sv
module daisy_arb_central
  import daisy_arb_pkg::*;
#(
  parameter int unsigned HOLD_LIMIT = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic br_n_i,
  input  logic bbsy_n_i,
  output logic bg_n_o,
  output logic bclr_n_o
);
  localparam int unsigned HW = $clog2(HOLD_LIMIT + 1);

  arb_state_e state_q;
  logic [HW-1:0] hold_q;
  logic bclr_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ARB_IDLE;
      hold_q   <= '0;
      bclr_n_q <= 1'b1;
    end else begin
      unique case (state_q)
        ARB_IDLE:  if (!br_n_i && bbsy_n_i) state_q <= ARB_GRANT;
        ARB_GRANT: begin
          if (!bbsy_n_i) begin
            state_q <= ARB_BUSY;
            hold_q  <= '0;
          end else if (br_n_i) begin
            state_q <= ARB_IDLE;   // requester withdrew
          end
        end
        ARB_BUSY: begin
          if (bbsy_n_i) begin
            state_q  <= ARB_IDLE;
            bclr_n_q <= 1'b1;
          end else begin
            if (hold_q != HW'(HOLD_LIMIT)) hold_q <= hold_q + 1'b1;
            if (hold_q == HW'(HOLD_LIMIT) && !br_n_i) bclr_n_q <= 1'b0;
          end
        end
        default: state_q <= ARB_IDLE;
      endcase
    end
  end

  assign bg_n_o   = (state_q != ARB_GRANT);
  assign bclr_n_o = bclr_n_q;
endmodule

// File: rtl/daisy_arb_slot.sv
module daisy_arb_slot
  import daisy_arb_pkg::*;
#(
  parameter int unsigned WORD_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic want_i,
  input  logic block_i,
  input  logic bg_n_i,
  input  logic bbsy_n_i,
  input  logic bclr_n_i,
  output logic bg_n_o,
  output logic br_n_o,
  output logic bbsy_n_o,
  output logic own_o,
  output logic word_done_o
);
  localparam int unsigned CW = $clog2(WORD_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(WORD_CYC - 1);

  rq_state_e state_q;
  logic [CW-1:0] cnt_q;
  logic last_beat;

  assign last_beat = (state_q == RQ_OWN) && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RQ_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        RQ_IDLE: if (want_i) state_q <= RQ_WAIT;
        RQ_WAIT: begin
          if (!want_i) begin
            state_q <= RQ_IDLE;
          end else if (!bg_n_i && bbsy_n_i) begin
            state_q <= RQ_OWN;
            cnt_q   <= '0;
          end
        end
        RQ_OWN: begin
          if (last_beat) begin
            cnt_q <= '0;
            // block mode keeps the bus unless work ran out or clear is seen
            if (!(block_i && want_i && bclr_n_i)) state_q <= RQ_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= RQ_IDLE;
      endcase
    end
  end

  assign bg_n_o      = (state_q == RQ_IDLE) ? bg_n_i : 1'b1;
  assign br_n_o      = (state_q != RQ_WAIT);
  assign bbsy_n_o    = (state_q != RQ_OWN);
  assign own_o       = (state_q == RQ_OWN);
  assign word_done_o = last_beat;
endmodule

// File: rtl/daisy_arb_top.sv
module daisy_arb_top #(
  parameter int unsigned N_SLOTS    = 4,
  parameter int unsigned WORD_CYC   = 4,
  parameter int unsigned HOLD_LIMIT = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_SLOTS-1:0] req_i,
  input  logic [N_SLOTS-1:0] block_i,
  output logic [N_SLOTS-1:0] own_o,
  output logic [N_SLOTS-1:0] word_done_o,
  output logic [N_SLOTS-1:0] grant_chain_o,
  output logic               br_n_o,
  output logic               bbsy_n_o,
  output logic               bclr_n_o
);
  logic [N_SLOTS:0]   bg_n;
  logic [N_SLOTS-1:0] br_n_drv, bbsy_n_drv;

  // open-drain lines modelled as wired-AND
  assign br_n_o   = &br_n_drv;
  assign bbsy_n_o = &bbsy_n_drv;

  daisy_arb_central #(.HOLD_LIMIT(HOLD_LIMIT)) u_central (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .br_n_i  (br_n_o),
    .bbsy_n_i(bbsy_n_o),
    .bg_n_o  (bg_n[0]),
    .bclr_n_o(bclr_n_o)
  );

  for (genvar k = 0; k < N_SLOTS; k++) begin : g_slot
    daisy_arb_slot #(.WORD_CYC(WORD_CYC)) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .want_i     (req_i[k]),
      .block_i    (block_i[k]),
      .bg_n_i     (bg_n[k]),
      .bbsy_n_i   (bbsy_n_o),
      .bclr_n_i   (bclr_n_o),
      .bg_n_o     (bg_n[k+1]),
      .br_n_o     (br_n_drv[k]),
      .bbsy_n_o   (bbsy_n_drv[k]),
      .own_o      (own_o[k]),
      .word_done_o(word_done_o[k])
    );
  end

  assign grant_chain_o = bg_n[N_SLOTS-1:0];
endmodule

// File: rtl/daisy_arb_chk.sv
module daisy_arb_chk #(
  parameter int unsigned N_SLOTS  = 4,
  parameter int unsigned WORD_CYC = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_SLOTS-1:0] req_i,
  input logic [N_SLOTS-1:0] block_i,
  input logic [N_SLOTS-1:0] own_o,
  input logic [N_SLOTS-1:0] word_done_o,
  input logic [N_SLOTS-1:0] grant_chain_o,
  input logic               br_n_o,
  input logic               bbsy_n_o,
  input logic               bclr_n_o
);
  int unsigned clr_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clr_len <= 0;
    else if (bclr_n_o) clr_len <= 0;
    else clr_len <= clr_len + 1;
  end

  assert_one_owner_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(own_o));

  assert_grant_when_free_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(grant_chain_o[0]) |-> ($past(bbsy_n_o) && !$past(br_n_o)));

  assert_grant_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!grant_chain_o[0] && !bbsy_n_o) |=> grant_chain_o[0]);

  assert_clear_bounded_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_len <= WORD_CYC + 1);

  for (genvar k = 0; k < N_SLOTS; k++) begin : g_a
    assert_single_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (word_done_o[k] && !block_i[k]) |=> !own_o[k]);
  end
endmodule

bind daisy_arb_top daisy_arb_chk #(.N_SLOTS(N_SLOTS), .WORD_CYC(WORD_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .block_i(block_i),
  .own_o(own_o), .word_done_o(word_done_o), .grant_chain_o(grant_chain_o),
  .br_n_o(br_n_o), .bbsy_n_o(bbsy_n_o), .bclr_n_o(bclr_n_o)
);

// File: tb/daisy_arb_top_bench.sv
module daisy_arb_top_bench;
  localparam int N = 4;
  localparam int W = 4;
  localparam int HL = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req = '0, blk = '0;
  logic [N-1:0] own, wdone, gchain;
  logic br_n, bbsy_n, bclr_n;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #4 clk = ~clk;  // 125 MHz

  daisy_arb_top #(.N_SLOTS(N), .WORD_CYC(W), .HOLD_LIMIT(HL)) u_daisy_arb_top (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .block_i(blk),
    .own_o(own), .word_done_o(wdone), .grant_chain_o(gchain),
    .br_n_o(br_n), .bbsy_n_o(bbsy_n), .bclr_n_o(bclr_n)
  );

  localparam logic [N-1:0] T_REQ [6] = '{4'b0001, 4'b1000, 4'b1010, 4'b1100, 4'b1111, 4'b0110};
  localparam logic [N-1:0] T_BLK [6] = '{4'b0000, 4'b0000, 4'b0000, 4'b1100, 4'b0000, 4'b0010};
  localparam logic [N-1:0] T_OWN [6] = '{4'b0001, 4'b1000, 4'b0010, 4'b0100, 4'b0001, 4'b0010};

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
      finish_run();
    end
  end

  initial begin
    int t;
    step(2);
    // R11 reset state
    chk(own == 0 && bbsy_n && bclr_n && br_n && gchain == '1, "R11", {own, gchain}, 8'h0f);
    rst_n = 1'b1;
    step(1);

    // table walk: R5 priority, R10 single owner
    for (int i = 0; i < 6; i++) begin
      req = T_REQ[i]; blk = T_BLK[i];
      t = 0;
      while (own == 0 && t < 40) begin step(1); t++; end
      chk(own == T_OWN[i], "R5", own, T_OWN[i]);
      chk($countones(own) <= 1, "R10", own, T_OWN[i]);
      req = '0;
      t = 0;
      while (!bbsy_n && t < 40) begin step(1); t++; end
      chk(bbsy_n == 1'b1, "R7", bbsy_n, 1);
      step(3);
    end

    // exact timing, single board at slot 1
    blk = '0; req = 4'b0010;
    step(1);
    chk(br_n == 1'b0, "R1", br_n, 0);
    step(1);
    chk(gchain[0] == 0 && gchain[1] == 0, "R3", gchain, 4'b1100);
    chk(gchain[2] == 1, "R3", gchain[2], 1);
    step(1);
    chk(own == 4'b0010 && bbsy_n == 0, "R4", own, 4'b0010);
    chk(gchain[2] == 1 && br_n == 1, "R4", {gchain[2], br_n}, 3);
    step(1);
    chk(gchain[0] == 1, "R6", gchain[0], 1);
    step(2);
    chk(bbsy_n == 0 && wdone == 4'b0010, "R7", wdone, 4'b0010);
    step(1);
    chk(bbsy_n == 1 && own == 0, "R7", own, 0);
    req = '0;
    step(4);

    // block owner with no competitor keeps the bus past the hold limit
    blk = 4'b0100; req = 4'b0100;
    t = 0;
    while (own == 0 && t < 20) begin step(1); t++; end
    step(HL + 3 * W);
    chk(own == 4'b0100 && bclr_n == 1, "R8", own, 4'b0100);

    // competitor arrives: clear, then handover
    req = 4'b0101;
    t = 0;
    while (bclr_n && t < 40) begin step(1); t++; end
    chk(bclr_n == 0, "R9", bclr_n, 0);
    t = 0;
    while (!bclr_n && t < 40) begin step(1); t++; end
    chk(t <= W + 1, "R9", t, W + 1);
    req = 4'b0001;
    t = 0;
    while (own != 4'b0001 && t < 20) begin step(1); t++; end
    chk(own == 4'b0001, "R9", own, 4'b0001);
    req = '0; blk = '0;
    step(W + 3);
    chk(own == 0 && bbsy_n && br_n, "R1", {own, bbsy_n, br_n}, 3);

    finish_run();
  end
endmodule